// File: doc/BRIEF.md
# Condition code flag update unit

This block holds the 8-bit condition code register of an 8/16-bit accumulator CPU and keeps its four arithmetic flags (negative, zero, overflow, carry) current. Each cycle the datapath may present an operation class (add, subtract, test, shift), a width select, both operands and the result the ALU produced. The unit derives the new flags from the sign bits of operands and result at the selected width, with no internal carry chain, and writes them into the register on the next clock edge. The four control bits in the upper nibble are never touched by an operation update.

Besides the operation path, the register can be loaded whole, or one of its eight bits can be set or cleared on its own. All three update sources share one write port with a fixed priority, and the register value is always visible on the output.

Top module: `ccr_unit`

## Requirements
- R1: The register bit order from bit 7 down to bit 0 is S, X, H, I, N, Z, V, C; a synchronous active-low reset loads 0xD0.
- R2: For an add (op_kind 0), C becomes the MSB of (a&b)|(b&~r)|(a&~r) and V the MSB of (a&b&~r)|(~a&~b&r), where the MSB is bit 7 when op_wide is 0 and bit 15 when op_wide is 1.
- R3: For a subtract (op_kind 1), C becomes the MSB of (~a&b)|(b&r)|(~a&r) and V the MSB of (a&~b&~r)|(~a&b&r), at the same selected MSB.
- R4: For every operation class, N equals the result MSB and Z is 1 exactly when the result is zero at the selected width; result bits above bit 7 have no effect in 8-bit mode.
- R5: For a test (op_kind 2), V is cleared, N and Z follow the result and C keeps its previous value.
- R6: For a shift (op_kind 3), C takes shift_carry, N and Z follow the result, and V becomes the new N XOR the new C.
- R7: An operation update leaves bits 7..4 (S, X, H, I) unchanged.
- R8: A flag write with flag_idx k (0 = C, 1 = V, 2 = Z, 3 = N, 4 = I, 5 = H, 6 = X, 7 = S) sets bit k to flag_bit and keeps the other seven bits.
- R9: A full load replaces all eight bits with load_data; ccr_q always shows the register.
- R10: Priority when several updates meet in one cycle: operation update over full load over single-flag write.
- R11: With no update request the register holds its value, whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation update is requested this cycle |
| op_kind | input | 2 | 0 add, 1 subtract, 2 test, 3 shift |
| op_wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| op_result | input | 16 | ALU result |
| shift_carry | input | 1 | Carry produced by the shifter |
| flag_wr | input | 1 | Single-flag write request |
| flag_idx | input | 3 | Index of the bit to write |
| flag_bit | input | 1 | Value for the selected bit |
| load_wr | input | 1 | Full-register load request |
| load_data | input | 8 | Value for a full load |
| ccr_q | output | 8 | Current register value |

## Verification
The bench builds the unit with its default parameters, a 16-bit data path and an 8-bit narrow width, so both MSB positions (bit 7 and bit 15) are exercised through the same ports. With the narrow width below the data width, the bench can place nonzero garbage above bit 7 in 8-bit operations and show that zero and sign detection look only at the low byte. Carry and overflow expectations are computed from true sums and differences and signed-overflow rules, not from the sign-bit formulas.

// File: rtl/ccr_pkg.sv
// Shared types and bit positions of the condition code unit.
// Assumes an 8-bit register with the order S X H I N Z V C (bit 7..0).
package ccr_pkg;

    localparam int CCR_W = 8;
    localparam int BIT_C = 0;
    localparam int BIT_V = 1;
    localparam int BIT_Z = 2;
    localparam int BIT_N = 3;
    localparam int CTRL_LO = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_TST = 2'd2,
        OP_SHF = 2'd3
    } op_kind_e;

    // New arithmetic flag values and per-flag write enables
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/ccr_width_view.sv
// Picks the sign bits of both operands and the result at the selected
// width and detects a zero result at that width.
// Assumes NARROW_W <= DATA_W; bits above the selected width are ignored.
module ccr_width_view #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] r,
    output logic              a_msb,
    output logic              b_msb,
    output logic              r_msb,
    output logic              r_zero
);
    localparam int WIDE_MSB   = DATA_W - 1;
    localparam int NARROW_MSB = NARROW_W - 1;

    generate
        if (NARROW_W < DATA_W) begin : g_two_widths
            // Select sign bits and zero test by width
            always_comb begin
                if (wide) begin
                    a_msb  = a[WIDE_MSB];
                    b_msb  = b[WIDE_MSB];
                    r_msb  = r[WIDE_MSB];
                    r_zero = (r == '0);
                end else begin
                    a_msb  = a[NARROW_MSB];
                    b_msb  = b[NARROW_MSB];
                    r_msb  = r[NARROW_MSB];
                    r_zero = (r[NARROW_MSB:0] == '0);
                end
            end
        end else begin : g_one_width
            logic unused_wide;
            // Only one width exists; the select has no effect
            always_comb begin
                unused_wide = wide;
                a_msb  = a[WIDE_MSB];
                b_msb  = b[WIDE_MSB];
                r_msb  = r[WIDE_MSB];
                r_zero = (r == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/ccr_flag_calc.sv
// Derives new N, Z, V, C values and their write enables from the
// operation class and the sign bits supplied by the width view.
// Assumes the sign bits already belong to the selected width.
module ccr_flag_calc
    import ccr_pkg::*;
(
    input  op_kind_e kind,
    input  logic     a_msb,
    input  logic     b_msb,
    input  logic     r_msb,
    input  logic     r_zero,
    input  logic     shift_c,
    output nzvc_t    flags,
    output nzvc_t    wr_en
);
    // Compute flag values per operation class
    always_comb begin
        flags.n = r_msb;
        flags.z = r_zero;
        flags.v = 1'b0;
        flags.c = 1'b0;
        wr_en   = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
        unique case (kind)
            OP_ADD: begin
                flags.c = (a_msb & b_msb) | (b_msb & ~r_msb) | (a_msb & ~r_msb);
                flags.v = (a_msb & b_msb & ~r_msb) | (~a_msb & ~b_msb & r_msb);
            end
            OP_SUB: begin
                flags.c = (~a_msb & b_msb) | (b_msb & r_msb) | (~a_msb & r_msb);
                flags.v = (a_msb & ~b_msb & ~r_msb) | (~a_msb & b_msb & r_msb);
            end
            OP_TST: begin
                flags.v  = 1'b0;
                wr_en.c  = 1'b0;
            end
            OP_SHF: begin
                flags.c = shift_c;
                flags.v = r_msb ^ shift_c;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ccr_reg.sv
// The condition code register with its three write sources.
// Priority: operation update, then full load, then single-flag write.
module ccr_reg
    import ccr_pkg::*;
#(
    parameter logic [CCR_W-1:0] RESET_VAL = 8'hD0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_upd,
    input  nzvc_t            op_flags,
    input  nzvc_t            op_wr_en,
    input  logic             load_wr,
    input  logic [CCR_W-1:0] load_data,
    input  logic             flag_wr,
    input  logic [2:0]       flag_idx,
    input  logic             flag_bit,
    output logic [CCR_W-1:0] q
);
    logic [CCR_W-1:0] nxt;

    // Merge the winning update source into the next value
    always_comb begin
        nxt = q;
        if (op_upd) begin
            if (op_wr_en.n) nxt[BIT_N] = op_flags.n;
            if (op_wr_en.z) nxt[BIT_Z] = op_flags.z;
            if (op_wr_en.v) nxt[BIT_V] = op_flags.v;
            if (op_wr_en.c) nxt[BIT_C] = op_flags.c;
        end else if (load_wr) begin
            nxt = load_data;
        end else if (flag_wr) begin
            nxt[flag_idx] = flag_bit;
        end
    end

    // Register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= nxt;
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> q == RESET_VAL);

    // R8
    single_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !op_upd && !load_wr) |=>
        (((q ^ $past(q)) & ~(8'b1 << $past(flag_idx))) == 8'h00) &&
        (q[$past(flag_idx)] == $past(flag_bit)));

    // R9
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && !op_upd) |=> q == $past(load_data));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_upd && !load_wr && !flag_wr) |=> $stable(q));

endmodule

// File: rtl/ccr_unit.sv
// Top of the condition code unit: width view, flag calculation and the
// register. Assumes the ALU result is presented in the same cycle as its
// operands; flags appear on ccr_q one clock later.
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int               DATA_W    = 16,
    parameter int               NARROW_W  = 8,
    parameter logic [CCR_W-1:0] RESET_VAL = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic              op_wide,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] op_result,
    input  logic              shift_carry,
    input  logic              flag_wr,
    input  logic [2:0]        flag_idx,
    input  logic              flag_bit,
    input  logic              load_wr,
    input  logic [CCR_W-1:0]  load_data,
    output logic [CCR_W-1:0]  ccr_q
);
    logic     a_msb, b_msb, r_msb, r_zero;
    op_kind_e kind;
    nzvc_t    flags, wr_en;

    // Cast the raw class code to the enumerated type
    always_comb kind = op_kind_e'(op_kind);

    ccr_width_view #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
    ) u_view (
        .wide  (op_wide),
        .a     (opnd_a),
        .b     (opnd_b),
        .r     (op_result),
        .a_msb (a_msb),
        .b_msb (b_msb),
        .r_msb (r_msb),
        .r_zero(r_zero)
    );

    ccr_flag_calc u_calc (
        .kind   (kind),
        .a_msb  (a_msb),
        .b_msb  (b_msb),
        .r_msb  (r_msb),
        .r_zero (r_zero),
        .shift_c(shift_carry),
        .flags  (flags),
        .wr_en  (wr_en)
    );

    ccr_reg #(
        .RESET_VAL(RESET_VAL)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_upd   (op_valid),
        .op_flags (flags),
        .op_wr_en (wr_en),
        .load_wr  (load_wr),
        .load_data(load_data),
        .flag_wr  (flag_wr),
        .flag_idx (flag_idx),
        .flag_bit (flag_bit),
        .q        (ccr_q)
    );

    // R7
    ctrl_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ccr_q[7:CTRL_LO] == $past(ccr_q[7:CTRL_LO]));

    // R5
    test_clears_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd2) |=> !ccr_q[BIT_V] && (ccr_q[BIT_C] == $past(ccr_q[BIT_C])));

    // R6
    shift_v_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd3) |=>
        (ccr_q[BIT_V] == (ccr_q[BIT_N] ^ ccr_q[BIT_C])) && (ccr_q[BIT_C] == $past(shift_carry)));

    // R4
    sign_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_wide) |=> ccr_q[BIT_N] == $past(op_result[DATA_W-1]));

    // R10
    op_over_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && load_wr) |=> ccr_q[7:CTRL_LO] == $past(ccr_q[7:CTRL_LO]));

endmodule

// File: tb/ccr_unit_bench.sv
module ccr_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic        op_wide = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, op_result = '0;
    logic        shift_carry = 1'b0;
    logic        flag_wr = 1'b0;
    logic [2:0]  flag_idx = '0;
    logic        flag_bit = 1'b0;
    logic        load_wr = 1'b0;
    logic [7:0]  load_data = '0;
    logic [7:0]  ccr_q;

    int          checks = 0;
    int          fails = 0;
    logic [7:0]  model = 8'hD0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  mon_e;
    string       mon_t;
    bit          done = 1'b0;

    ccr_unit u_ccr_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_wide(op_wide), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_result(op_result), .shift_carry(shift_carry), .flag_wr(flag_wr),
        .flag_idx(flag_idx), .flag_bit(flag_bit), .load_wr(load_wr),
        .load_data(load_data), .ccr_q(ccr_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare the register one step after each driven cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            checks++;
            if (ccr_q !== mon_e) begin
                fails++;
                $display("FAIL %s: ccr_q=%02h expected=%02h", mon_t, ccr_q, mon_e);
            end
        end
    end

    // Driver: apply one cycle of inputs and queue the expected register
    task automatic drive(input logic v, input logic [1:0] k, input logic w,
                         input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                         input logic sc, input logic fwe, input logic [2:0] fs,
                         input logic fv, input logic le, input logic [7:0] lv,
                         input logic [7:0] exp, input string tag);
        @(negedge clk);
        op_valid = v; op_kind = k; op_wide = w;
        opnd_a = a; opnd_b = b; op_result = r; shift_carry = sc;
        flag_wr = fwe; flag_idx = fs; flag_bit = fv;
        load_wr = le; load_data = lv;
        model = exp;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic do_add(input logic w, input logic [15:0] a, input logic [15:0] b,
                          input logic le, input logic fwe, input string tag);
        logic [16:0] s;
        logic [15:0] r;
        logic n, z, v, c;
        if (w) begin
            s = {1'b0, a} + {1'b0, b};
            r = s[15:0]; c = s[16]; n = r[15]; z = (r == 0);
            v = (a[15] == b[15]) && (r[15] != a[15]);
        end else begin
            s = {9'b0, a[7:0]} + {9'b0, b[7:0]};
            r = {a[15:8] ^ 8'h5A, s[7:0]}; c = s[8]; n = r[7]; z = (r[7:0] == 0);
            v = (a[7] == b[7]) && (r[7] != a[7]);
        end
        drive(1'b1, 2'd0, w, a, b, r, 1'b0, fwe, 3'd7, 1'b0, le, 8'h00,
              {model[7:4], n, z, v, c}, tag);
    endtask

    task automatic do_sub(input logic w, input logic [15:0] a, input logic [15:0] b,
                          input string tag);
        logic [15:0] r;
        logic n, z, v, c;
        if (w) begin
            r = a - b; c = (a < b); n = r[15]; z = (r == 0);
            v = (a[15] != b[15]) && (r[15] != a[15]);
        end else begin
            r[7:0] = a[7:0] - b[7:0]; r[15:8] = 8'hC3;
            c = (a[7:0] < b[7:0]); n = r[7]; z = (r[7:0] == 0);
            v = (a[7] != b[7]) && (r[7] != a[7]);
        end
        drive(1'b1, 2'd1, w, a, b, r, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00,
              {model[7:4], n, z, v, c}, tag);
    endtask

    task automatic do_tst(input logic w, input logic [15:0] r, input string tag);
        logic n, z;
        n = w ? r[15] : r[7];
        z = w ? (r == 0) : (r[7:0] == 0);
        drive(1'b1, 2'd2, w, 16'hFFFF, 16'hFFFF, r, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00,
              {model[7:4], n, z, 1'b0, model[0]}, tag);
    endtask

    task automatic do_shf(input logic w, input logic [15:0] r, input logic sc, input string tag);
        logic n, z;
        n = w ? r[15] : r[7];
        z = w ? (r == 0) : (r[7:0] == 0);
        drive(1'b1, 2'd3, w, 16'h0, 16'h0, r, sc, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00,
              {model[7:4], n, z, n ^ sc, sc}, tag);
    endtask

    task automatic do_flag(input logic [2:0] idx, input logic val, input string tag);
        logic [7:0] e;
        e = model; e[idx] = val;
        drive(1'b0, 2'd0, 1'b0, 16'hAAAA, 16'h5555, 16'h0000, 1'b1, 1'b1, idx, val, 1'b0, 8'h00,
              e, tag);
    endtask

    task automatic do_load(input logic [7:0] val, input logic fwe, input string tag);
        drive(1'b0, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, fwe, 3'd0, ~val[0], 1'b1, val,
              val, tag);
    endtask

    task automatic do_idle(input string tag);
        drive(1'b0, 2'd3, 1'b1, 16'h1234, 16'h8765, 16'h0000, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 8'hFF,
              model, tag);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value and bit order
        checks++;
        if (ccr_q !== 8'hD0) begin
            fails++;
            $display("FAIL R1: ccr_q=%02h expected=d0", ccr_q);
        end
        rst_n = 1'b1;
        // R2 add, narrow and wide, with R4 upper-bit garbage in 8-bit mode
        do_add(1'b0, 16'h127F, 16'h3401, 1'b0, 1'b0, "R2 add8 overflow");
        do_add(1'b0, 16'h00FF, 16'h0001, 1'b0, 1'b0, "R4 add8 zero with upper bits");
        do_add(1'b1, 16'hFFFF, 16'h0001, 1'b0, 1'b0, "R2 add16 carry zero");
        do_add(1'b1, 16'h8000, 16'h8000, 1'b0, 1'b0, "R2 add16 carry overflow");
        do_add(1'b1, 16'h1234, 16'h0101, 1'b0, 1'b0, "R2 add16 plain");
        // R3 subtract
        do_sub(1'b0, 16'h0000, 16'h0001, "R3 sub8 borrow");
        do_sub(1'b0, 16'h0080, 16'h0001, "R3 sub8 overflow");
        do_sub(1'b1, 16'h8000, 16'h0001, "R3 sub16 overflow");
        do_sub(1'b1, 16'h0005, 16'h0005, "R3 sub16 zero");
        do_sub(1'b1, 16'h0001, 16'hFFFF, "R3 sub16 borrow");
        // R5 test keeps C, clears V
        do_tst(1'b1, 16'h8000, "R5 tst16 negative");
        do_tst(1'b0, 16'hAB00, "R5 tst8 zero R4");
        // R6 shift
        do_shf(1'b0, 16'h0000, 1'b1, "R6 shift zero carry");
        do_shf(1'b1, 16'h8000, 1'b1, "R6 shift neg carry");
        do_shf(1'b1, 16'h4000, 1'b0, "R6 shift plain");
        do_shf(1'b0, 16'h0080, 1'b0, "R6 shift8 neg");
        // R8 single-flag writes across every index
        for (int i = 0; i < 8; i++) do_flag(3'(i), 1'b1, "R8 set");
        for (int i = 0; i < 8; i++) do_flag(3'(7 - i), i[0], "R8 mixed");
        // R9 full load; R7 op after load keeps upper nibble
        do_load(8'h5A, 1'b0, "R9 load");
        do_add(1'b1, 16'h7FFF, 16'h0001, 1'b0, 1'b0, "R7 add keeps ctrl bits");
        do_load(8'hA5, 1'b0, "R9 load2");
        do_shf(1'b0, 16'h0040, 1'b1, "R7 shift keeps ctrl bits");
        // R10 priority cases
        do_add(1'b1, 16'h0001, 16'h0001, 1'b1, 1'b1, "R10 op over load and flag");
        do_load(8'h3C, 1'b1, "R10 load over flag");
        // R11 idle holds
        do_idle("R11 idle");
        do_idle("R11 idle2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule